// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter

This block sits between the interrupt sources of a system and one hardware thread. It keeps the thread's current priority and at most one accepted external interrupt. For each delivery request from a source it decides, in one cycle, whether to take the request or hand it back. Priorities are encoded so that a smaller number is more favoured. The all-ones code means the thread is not serving any interrupt. The block raises an interrupt line to the thread whenever it holds work that beats the thread's current priority.

The thread talks to the block through a small register bus. Reading the acknowledge register claims the best waiting interrupt. The read returns that interrupt's source together with the priority the thread had before, and it raises the thread priority to the claimed level. Writing the acknowledge register sends an end-of-interrupt message to the named source and may lower the thread priority at the same time. A separate register changes only the priority. A third register arms the thread's own inter-processor interrupt: another agent writes a priority into it.

A request may be handed back to its source, or an already accepted interrupt may be displaced and returned. In both cases the source must retry later. The block keeps no memory of either.

Top module: `irq_presenter`

## Requirements
- R1: After reset the thread priority and the inter-processor priority both read back as 15 (the least favoured code). Nothing is pending, and irq_out, req_accept, req_reject, bump_valid, eoi_valid and rd_valid are all low.
- R2: A request whose priority is numerically greater than or equal to the thread priority gets req_reject in the cycle after it is presented, and it is not stored.
- R3: A request whose priority is numerically lower than the thread priority is accepted (req_accept one cycle later), provided it is also strictly lower than any interrupt already pending. Any such displaced interrupt is returned in the same cycle on bump_valid with its source on bump_src. A request equal to or worse than the pending one is rejected, and the pending one is kept.
- R4: irq_out is high in the cycle after the stored state holds an external interrupt, or an armed inter-processor interrupt, whose priority is numerically below the thread priority. Otherwise irq_out is low.
- R5: A read of register 0 (acknowledge) returns the old thread priority in rd_data[11:8] and the claimed source in rd_data[7:0], with rd_valid, one cycle later. It sets the thread priority to the claimed interrupt's priority, forgets that interrupt, and irq_out drops.
- R6: An acknowledge read with nothing presentable returns source 0 and the current priority, and it changes no state.
- R7: A write to register 0 with priority in bus_wdata[11:8] and source in bus_wdata[7:0] pulses eoi_valid one cycle later, with eoi_src equal to the written source. The thread priority takes the written value only if that value is numerically greater than or equal to the current one. Otherwise the priority is left alone, but the end-of-interrupt is still sent.
- R8: A write to register 1 sets the thread priority to bus_wdata[11:8] in either direction and produces no end-of-interrupt.
- R9: A write to register 2 arms the inter-processor interrupt at priority bus_wdata[11:8]; 15 disarms it. It is presented as source 2 and wins a tie against an external interrupt of equal priority. Claiming it returns register 2 to 15. While it is not more favoured than the thread priority, it stays armed.
- R10: After any bus operation, an accepted external interrupt whose priority is no longer strictly below the thread priority is returned on bump_valid with its source.
- R11: Reads of register 1 and register 2 return the thread priority and the inter-processor priority respectively, in rd_data[11:8] with the low byte zero. Register 3 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Delivery request present this cycle |
| req_src | input | SRC_W | Source number of the request (not 0 or 2) |
| req_prio | input | PRIO_W | Priority of the request |
| req_accept | output | 1 | Request of the previous cycle taken |
| req_reject | output | 1 | Request of the previous cycle handed back |
| bump_valid | output | 1 | A stored interrupt is returned to its source |
| bump_src | output | SRC_W | Source of the returned interrupt |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (wins over bus_rd) |
| bus_addr | input | 2 | Register select: 0 acknowledge, 1 priority, 2 inter-processor |
| bus_wdata | input | SRC_W+PRIO_W | Write data: priority high, source low |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | SRC_W+PRIO_W | Read data: priority high, source low |
| eoi_valid | output | 1 | End-of-interrupt message valid |
| eoi_src | output | SRC_W | Source the end-of-interrupt is addressed to |
| irq_out | output | 1 | Interrupt line to the thread |

## Verification
The hardest state to reach is two interrupts of equal priority competing, one external and one inter-processor. When that happens, one claim must present the inter-processor interrupt and, in the same cycle, return the external one on the bump channel. The stimulus reaches this state by delivering an external request first and then arming register 2 with the same code before reading the acknowledge register. A second case checks that an inter-processor interrupt stays latched while it is outranked. A pending external interrupt is claimed first, and the end-of-interrupt that lowers the priority must then bring irq_out back up. Sweeps over every pair of thread priority and request priority, every pair of competing requests, and every pair of acknowledge-write priorities cover the admission and no-raise rules.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACK_RD,
    OP_ACK_WR,
    OP_PRIO_WR,
    OP_IPI_WR,
    OP_PRIO_RD,
    OP_IPI_RD,
    OP_NULL_RD
  } bus_op_e;

  localparam logic [1:0] SEL_ACK  = 2'd0;
  localparam logic [1:0] SEL_PRIO = 2'd1;
  localparam logic [1:0] SEL_IPI  = 2'd2;
endpackage

// File: rtl/irqp_decode.sv
module irqp_decode import irqp_pkg::*; #(
  parameter int SRC_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic                    rd,
  input  logic                    wr,
  input  logic [1:0]              addr,
  input  logic [SRC_W+PRIO_W-1:0] wdata,
  output bus_op_e                 op,
  output logic [PRIO_W-1:0]       w_prio,
  output logic [SRC_W-1:0]        w_src
);
  assign w_prio = wdata[SRC_W +: PRIO_W];
  assign w_src  = wdata[SRC_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      case (addr)
        SEL_ACK:  op = OP_ACK_WR;
        SEL_PRIO: op = OP_PRIO_WR;
        SEL_IPI:  op = OP_IPI_WR;
        default:  op = OP_NONE;
      endcase
    end else if (rd) begin
      case (addr)
        SEL_ACK:  op = OP_ACK_RD;
        SEL_PRIO: op = OP_PRIO_RD;
        SEL_IPI:  op = OP_IPI_RD;
        default:  op = OP_NULL_RD;
      endcase
    end
  end
endmodule

// File: rtl/irqp_pick.sv
module irqp_pick #(
  parameter int PRIO_W = 4
) (
  input  logic [PRIO_W-1:0] cpu_prio,
  input  logic              ext_valid,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              take_ipi,
  output logic              take_ext
);
  localparam logic [PRIO_W-1:0] IDLE_CODE = '1;

  logic ipi_live;

  // an armed IPI is presentable only when it beats the thread priority
  assign ipi_live = (ipi_prio != IDLE_CODE) && (ipi_prio < cpu_prio);
  // the IPI wins ties against the stored external interrupt
  assign take_ipi = ipi_live && (!ext_valid || (ipi_prio <= ext_prio));
  assign take_ext = ext_valid && !take_ipi;
endmodule

// File: rtl/irqp_admit.sv
module irqp_admit #(
  parameter int PRIO_W = 4
) (
  input  logic              req_valid,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] cpu_mid,
  input  logic              ext_mid,
  input  logic [PRIO_W-1:0] ext_prio,
  output logic              drop,
  output logic              keep,
  output logic              accept,
  output logic              reject,
  output logic              bump
);
  // a stored interrupt that no longer beats the thread priority goes back
  assign drop   = ext_mid && (ext_prio >= cpu_mid);
  assign keep   = ext_mid && !drop;
  assign accept = req_valid && (req_prio < cpu_mid) && (!keep || (req_prio < ext_prio));
  assign reject = req_valid && !accept;
  assign bump   = drop || (accept && keep);
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter import irqp_pkg::*; #(
  parameter int SRC_W    = 8,
  parameter int PRIO_W   = 4,
  parameter int NONE_SRC = 0,
  parameter int IPI_SRC  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  output logic                    req_accept,
  output logic                    req_reject,
  output logic                    bump_valid,
  output logic [SRC_W-1:0]        bump_src,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [1:0]              bus_addr,
  input  logic [SRC_W+PRIO_W-1:0] bus_wdata,
  output logic                    rd_valid,
  output logic [SRC_W+PRIO_W-1:0] rd_data,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    irq_out
);
  localparam int                DW        = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] IDLE_CODE = '1;
  localparam logic [SRC_W-1:0]  NONE_ID   = SRC_W'(NONE_SRC);
  localparam logic [SRC_W-1:0]  IPI_ID    = SRC_W'(IPI_SRC);
  localparam logic [SRC_W-1:0]  ZERO_SRC  = '0;

  // architectural state
  logic [PRIO_W-1:0] cpu_q;
  logic              pend_v_q;
  logic [SRC_W-1:0]  pend_src_q;
  logic [PRIO_W-1:0] pend_p_q;
  logic [PRIO_W-1:0] ipi_q;

  bus_op_e           op;
  logic [PRIO_W-1:0] w_prio;
  logic [SRC_W-1:0]  w_src;
  logic              take_ipi, take_ext;

  // state after the bus operation, before admission
  logic [PRIO_W-1:0] cpu_m, ipi_m;
  logic              pv_m;
  logic              rvalid_n, eoi_n;
  logic [DW-1:0]     rdata_n;

  logic drop, keep, accept, reject, bump;
  logic pend_v_n, irq_n;

  irqp_decode #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .op(op), .w_prio(w_prio), .w_src(w_src)
  );

  irqp_pick #(.PRIO_W(PRIO_W)) u_pick (
    .cpu_prio(cpu_q), .ext_valid(pend_v_q), .ext_prio(pend_p_q), .ipi_prio(ipi_q),
    .take_ipi(take_ipi), .take_ext(take_ext)
  );

  always_comb begin
    cpu_m    = cpu_q;
    pv_m     = pend_v_q;
    ipi_m    = ipi_q;
    rvalid_n = 1'b0;
    rdata_n  = '0;
    eoi_n    = 1'b0;
    case (op)
      OP_ACK_RD: begin
        rvalid_n = 1'b1;
        if (take_ipi) begin
          rdata_n = {cpu_q, IPI_ID};
          cpu_m   = ipi_q;
          ipi_m   = IDLE_CODE;
        end else if (take_ext) begin
          rdata_n = {cpu_q, pend_src_q};
          cpu_m   = pend_p_q;
          pv_m    = 1'b0;
        end else begin
          rdata_n = {cpu_q, NONE_ID};
        end
      end
      OP_ACK_WR: begin
        eoi_n = 1'b1;
        // an end-of-interrupt write may only keep or lower the priority
        if (w_prio >= cpu_q) cpu_m = w_prio;
      end
      OP_PRIO_WR: cpu_m = w_prio;
      OP_IPI_WR:  ipi_m = w_prio;
      OP_PRIO_RD: begin
        rvalid_n = 1'b1;
        rdata_n  = {cpu_q, ZERO_SRC};
      end
      OP_IPI_RD: begin
        rvalid_n = 1'b1;
        rdata_n  = {ipi_q, ZERO_SRC};
      end
      OP_NULL_RD: rvalid_n = 1'b1;
      default: ;
    endcase
  end

  irqp_admit #(.PRIO_W(PRIO_W)) u_admit (
    .req_valid(req_valid), .req_prio(req_prio), .cpu_mid(cpu_m),
    .ext_mid(pv_m), .ext_prio(pend_p_q),
    .drop(drop), .keep(keep), .accept(accept), .reject(reject), .bump(bump)
  );

  assign pend_v_n = accept || keep;
  assign irq_n    = pend_v_n || ((ipi_m != IDLE_CODE) && (ipi_m < cpu_m));

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_q      <= IDLE_CODE;
      ipi_q      <= IDLE_CODE;
      pend_v_q   <= 1'b0;
      pend_src_q <= '0;
      pend_p_q   <= IDLE_CODE;
      req_accept <= 1'b0;
      req_reject <= 1'b0;
      bump_valid <= 1'b0;
      bump_src   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      irq_out    <= 1'b0;
    end else begin
      cpu_q      <= cpu_m;
      ipi_q      <= ipi_m;
      pend_v_q   <= pend_v_n;
      if (accept) begin
        pend_src_q <= req_src;
        pend_p_q   <= req_prio;
      end
      req_accept <= accept;
      req_reject <= reject;
      bump_valid <= bump;
      bump_src   <= pend_src_q;
      rd_valid   <= rvalid_n;
      rd_data    <= rdata_n;
      eoi_valid  <= eoi_n;
      eoi_src    <= w_src;
      irq_out    <= irq_n;
    end
  end
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_accept,
  input logic              req_reject,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic              rd_valid,
  input logic              eoi_valid,
  input logic              irq_out,
  input logic [PRIO_W-1:0] cpu_q,
  input logic              pend_v_q,
  input logic [PRIO_W-1:0] pend_p_q,
  input logic [PRIO_W-1:0] ipi_q
);
  localparam logic [PRIO_W-1:0] IDLE_CODE = '1;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2 / R3: every request gets exactly one answer one cycle later
  a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((req_accept || req_reject) == $past(req_valid)));
  a_r3_not_both: assert property (@(posedge clk) disable iff (rst)
    !(req_accept && req_reject));
  // R10: a stored external interrupt always beats the thread priority
  a_r10_stored_beats_cpu: assert property (@(posedge clk) disable iff (rst)
    pend_v_q |-> (pend_p_q < cpu_q));
  // R7: an end-of-interrupt write never raises the priority
  a_r7_no_raise: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(bus_wr && (bus_addr == 2'd0))) |-> (cpu_q >= $past(cpu_q)));
  // R7 / R8: end-of-interrupt only after an acknowledge write
  a_r8_eoi_only_ack_write: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (eoi_valid == $past(bus_wr && (bus_addr == 2'd0))));
  // R4: the line is raised only when something is held
  a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (pend_v_q || (ipi_q != IDLE_CODE)));
  // R5: read data answers each read one cycle later
  a_r5_read_answer: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (rd_valid == $past(bus_rd && !bus_wr)));
endmodule

bind irq_presenter irqp_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
  .req_reject(req_reject), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .rd_valid(rd_valid), .eoi_valid(eoi_valid), .irq_out(irq_out),
  .cpu_q(cpu_q), .pend_v_q(pend_v_q), .pend_p_q(pend_p_q), .ipi_q(ipi_q)
);

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;
  localparam int SW = 8;
  localparam int PW = 4;
  localparam int DW = SW + PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [PW-1:0] req_prio = '0;
  logic          req_accept, req_reject, bump_valid;
  logic [SW-1:0] bump_src;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          eoi_valid;
  logic [SW-1:0] eoi_src;
  logic          irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .req_accept(req_accept), .req_reject(req_reject), .bump_valid(bump_valid),
    .bump_src(bump_src), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input int a, input int p, input int s);
    bus_addr  = 2'(a);
    bus_wdata = DW'((p << SW) | s);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic brd(input int a, output int d);
    bus_addr = 2'(a);
    bus_rd   = 1'b1;
    @(negedge clk);
    d        = int'(rd_data);
    chk("R5 rd_valid", rd_valid, 1);
    bus_rd   = 1'b0;
  endtask

  task automatic dlv(input int p, input int s);
    req_prio  = PW'(p);
    req_src   = SW'(s);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d, s, wsrc, wp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", irq_out, 0);
    chk("R1 eoi_valid", eoi_valid, 0);
    chk("R1 bump_valid", bump_valid, 0);
    chk("R1 req_accept", req_accept, 0);
    chk("R1 req_reject", req_reject, 0);
    chk("R1 rd_valid", rd_valid, 0);
    brd(1, d); chk("R1 thread prio", d, 15 << 8);
    brd(2, d); chk("R1 ipi prio", d, 15 << 8);

    // R6 claim with nothing held
    brd(0, d); chk("R6 empty claim", d, 15 << 8);
    brd(1, d); chk("R6 prio kept", d, 15 << 8);

    // R2 / R3 / R5 / R7: all thread x request priorities
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 16; r++) begin
        s = 16 + r;
        bwr(1, c, 0);
        dlv(r, s);
        if (r < c) begin
          chk("R3 accept", req_accept, 1);
          chk("R3 no reject", req_reject, 0);
          chk("R4 irq raised", irq_out, 1);
          brd(0, d); chk("R5 claim data", d, (c << 8) | s);
          chk("R5 irq dropped", irq_out, 0);
          brd(1, d); chk("R5 prio raised", d, r << 8);
          bwr(0, 15, s);
          chk("R7 eoi pulse", eoi_valid, 1);
          chk("R7 eoi source", eoi_src, s);
        end else begin
          chk("R2 reject", req_reject, 1);
          chk("R2 no accept", req_accept, 0);
          chk("R2 irq low", irq_out, 0);
          brd(0, d); chk("R2 not stored", d, c << 8);
        end
      end
    end

    // R3: competing requests
    bwr(1, 15, 0);
    for (int p1 = 0; p1 < 15; p1++) begin
      for (int p2 = 0; p2 < 15; p2++) begin
        dlv(p1, 'h40);
        chk("R3 first accept", req_accept, 1);
        dlv(p2, 'h80);
        if (p2 < p1) begin
          chk("R3 better accept", req_accept, 1);
          chk("R3 displaced", bump_valid, 1);
          chk("R3 displaced src", bump_src, 'h40);
          wsrc = 'h80; wp = p2;
        end else begin
          chk("R3 worse reject", req_reject, 1);
          chk("R3 no displace", bump_valid, 0);
          wsrc = 'h40; wp = p1;
        end
        brd(0, d); chk("R3 winner claimed", d, (15 << 8) | wsrc);
        brd(1, d); chk("R5 winner prio", d, wp << 8);
        bwr(0, 15, wsrc);
        chk("R4 nothing left", irq_out, 0);
      end
    end

    // R7 / R8: end-of-interrupt write never raises priority
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 16; w++) begin
        bwr(1, c, 0);
        chk("R8 no eoi", eoi_valid, 0);
        bwr(0, w, 'h33);
        chk("R7 eoi pulse", eoi_valid, 1);
        chk("R7 eoi source", eoi_src, 'h33);
        brd(1, d); chk("R7 prio result", d, ((w >= c) ? w : c) << 8);
      end
    end

    // R10: raising priority hands back a stored interrupt
    bwr(1, 15, 0);
    dlv(6, 'h21);
    chk("R3 accept", req_accept, 1);
    bwr(1, 7, 0);
    chk("R10 still held", bump_valid, 0);
    chk("R4 irq held", irq_out, 1);
    bwr(1, 4, 0);
    chk("R10 handed back", bump_valid, 1);
    chk("R10 handed back src", bump_src, 'h21);
    chk("R10 irq low", irq_out, 0);
    bwr(1, 15, 0);
    chk("R10 gone irq", irq_out, 0);
    brd(0, d); chk("R10 gone claim", d, 15 << 8);

    // R9: basic IPI
    bwr(2, 5, 0);
    chk("R9 irq", irq_out, 1);
    brd(2, d); chk("R11 ipi readback", d, 5 << 8);
    brd(0, d); chk("R9 ipi claim", d, (15 << 8) | 2);
    chk("R9 irq low", irq_out, 0);
    brd(2, d); chk("R9 ipi cleared", d, 15 << 8);
    brd(1, d); chk("R11 prio readback", d, 5 << 8);
    bwr(0, 15, 2);
    chk("R7 ipi eoi src", eoi_src, 2);

    // R9 / R10: tie between external and IPI
    dlv(5, 'h21);
    bwr(2, 5, 0);
    chk("R4 irq tie", irq_out, 1);
    brd(0, d); chk("R9 ipi wins tie", d, (15 << 8) | 2);
    chk("R10 tie handback", bump_valid, 1);
    chk("R10 tie handback src", bump_src, 'h21);
    chk("R4 irq after tie", irq_out, 0);
    bwr(0, 15, 2);

    // R9: outranked IPI stays armed
    dlv(2, 'h23);
    bwr(2, 6, 0);
    brd(0, d); chk("R9 ext first", d, (15 << 8) | 'h23);
    chk("R9 ipi outranked", irq_out, 0);
    bwr(0, 15, 'h23);
    chk("R4 ipi resurfaces", irq_out, 1);
    brd(0, d); chk("R9 ipi later", d, (15 << 8) | 2);
    bwr(0, 15, 2);

    // R9: IPI armed below thread priority
    bwr(1, 3, 0);
    bwr(2, 5, 0);
    chk("R9 masked ipi", irq_out, 0);
    bwr(1, 15, 0);
    chk("R9 unmasked ipi", irq_out, 1);
    brd(0, d); chk("R9 claim", d, (15 << 8) | 2);
    bwr(0, 15, 2);

    // R11: unused register
    bwr(3, 9, 'h55);
    chk("R11 no eoi", eoi_valid, 0);
    brd(3, d); chk("R11 reads zero", d, 0);
    brd(1, d); chk("R11 prio untouched", d, 15 << 8);
    brd(2, d); chk("R11 ipi untouched", d, 15 << 8);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule